// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block watches an external event line and, on the first sampled high level of each pulse, freezes the calendar's running values: the subsecond counter, the time of day and the date. It stores them in read-only capture registers and raises a pending flag. Software reads the frozen values, then acknowledges by writing ones to a clear register. The event line is edge-detected, so a level held high for many cycles is one event.

Only one set of values is held. If a further event arrives while the pending flag is still up, the stored values stay as they are and an overflow flag is raised instead. This tells software that at least one event was lost. The date snapshot keeps the day, month and weekday fields but has no year, so the year field of a capture always reads as zero. Capture happens only while the arm bit of the control register is set.

Top module: `evt_stamp_capture`

## Requirements
- R1: After reset, the pending flag, the overflow flag, the arm bit and all three capture registers are zero.
- R2: The arm bit is bit 25 of the control register at word address 0. While it is 0, an event changes neither the flags nor the captures. It reads back as written.
- R3: With arm set and the pending flag clear, an event loads the captures and sets the pending flag. Pending is bit 3 of the status register at address 1. Both changes are visible after the clock edge that first samples the event line high. The subsecond value is stored whole. The time is stored in its input layout: seconds units [3:0], seconds tens [6:4], minutes units [11:8], minutes tens [14:12], hour units [19:16], hour tens [21:20] and the PM bit [22]. Bits 7 and 15 of the time are stored as zero.
- R4: The date capture keeps day units [3:0], day tens [5:4], month units [11:8], month tens [12] and weekday [15:13]. Bits [7:6] and the year bits [23:16] are stored as zero.
- R5: An event line held high for several cycles produces exactly one capture and no overflow.
- R6: An event that arrives while the pending flag is set sets the overflow flag (status bit 4) and leaves all captures unchanged.
- R7: Writing to the clear register at address 2 works bit by bit. A 1 in bit 3 clears the pending flag and a 1 in bit 4 clears the overflow flag. Zero bits have no effect.
- R8: An event in the same cycle as a pending-flag clear wins. The flag stays set, the new values are captured and no overflow is raised.
- R9: An overflow raised in the same cycle as an overflow clear wins, so the overflow flag stays set.
- R10: A read strobe loads reg_rdata at the next clock edge, and reg_rdata holds its value between reads. The readable addresses are: the control register, the status register, the subsecond capture at 4, the time capture at 5 and the date capture at 6. The clear register and unmapped addresses read as zero.
- R11: Writes to the status or capture addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| live_subsec | input | SS_W | Running subsecond count |
| live_time | input | 23 | Running time of day, packed BCD |
| live_date | input | 24 | Running date, packed BCD including year |
| evt_in | input | 1 | External event line, synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| cap_subsec | output | SS_W | Captured subsecond count |
| cap_time | output | 23 | Captured time |
| cap_date | output | 24 | Captured date, year zero |
| stamp_flag | output | 1 | Capture pending |
| ovf_flag | output | 1 | Event lost while pending |

## Verification
The assertions assume that evt_in is already synchronous to clk. They also assume that reg_wr and reg_rd are never asserted in the same cycle, so the delayed read always reflects the state before the write. The bench changes evt_in and the strobes only on the falling clock edge. It never raises read and write together, and it always lets evt_in sit low for at least one rising edge before the next pulse. Under these conditions every flag rise can be traced to a single qualified edge.

// File: rtl/evts_pkg.sv
`timescale 1ns/1ps
package evts_pkg;

    localparam int TIME_W = 23;
    localparam int DATE_W = 24;

    localparam int OFF_CTRL   = 0;
    localparam int OFF_STAT   = 1;
    localparam int OFF_CLR    = 2;
    localparam int OFF_CAP_SS = 4;
    localparam int OFF_CAP_TM = 5;
    localparam int OFF_CAP_DT = 6;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_CLR,
        SEL_SS,
        SEL_TM,
        SEL_DT
    } reg_sel_e;

    typedef struct packed {
        logic       pm;
        logic [1:0] hr_t;
        logic [3:0] hr_u;
        logic       gap_b;
        logic [2:0] mn_t;
        logic [3:0] mn_u;
        logic       gap_a;
        logic [2:0] sc_t;
        logic [3:0] sc_u;
    } tod_t;

    typedef struct packed {
        logic [3:0] yr_t;
        logic [3:0] yr_u;
        logic [2:0] wday;
        logic       mo_t;
        logic [3:0] mo_u;
        logic [1:0] gap;
        logic [1:0] dy_t;
        logic [3:0] dy_u;
    } cal_t;

    function automatic tod_t tod_keep(input tod_t t);
        tod_t r;
        r       = t;
        r.gap_a = 1'b0;
        r.gap_b = 1'b0;
        return r;
    endfunction

    function automatic cal_t cal_keep(input cal_t d);
        cal_t r;
        r      = d;
        r.yr_t = '0;
        r.yr_u = '0;
        r.gap  = '0;
        return r;
    endfunction

endpackage

// File: rtl/evts_edge.sv
`timescale 1ns/1ps
module evts_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic arm,
    output logic rise,
    output logic hit
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
    assign hit  = rise & arm;

    AST_ONE_RISE_PER_LEVEL: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise); // R5

endmodule

// File: rtl/evts_slot.sv
`timescale 1ns/1ps
module evts_slot import evts_pkg::*; #(
    parameter int SS_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hit,
    input  logic            clr_stamp,
    input  logic            clr_ovf,
    input  logic [SS_W-1:0] live_ss,
    input  tod_t            live_tm,
    input  cal_t            live_dt,
    output logic [SS_W-1:0] cap_ss,
    output tod_t            cap_tm,
    output cal_t            cap_dt,
    output logic            stamp_q,
    output logic            ovf_q
);
    logic take;
    logic lost;

    assign take = hit && (!stamp_q || clr_stamp);
    assign lost = hit && stamp_q && !clr_stamp;

    always_ff @(posedge clk) begin
        if (rst) begin
            stamp_q <= 1'b0;
            ovf_q   <= 1'b0;
            cap_ss  <= '0;
            cap_tm  <= '0;
            cap_dt  <= '0;
        end else begin
            if (take)           stamp_q <= 1'b1;
            else if (clr_stamp) stamp_q <= 1'b0;

            if (lost)           ovf_q <= 1'b1;
            else if (clr_ovf)   ovf_q <= 1'b0;

            if (take) begin
                cap_ss <= live_ss;
                cap_tm <= tod_keep(live_tm);
                cap_dt <= cal_keep(live_dt);
            end
        end
    end

    AST_HOLD_WHILE_PENDING: assert property (@(posedge clk) disable iff (rst)
        (stamp_q && !clr_stamp) |=> ($stable(cap_ss) && $stable(cap_tm) && $stable(cap_dt))); // R6
    AST_OVF_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> $past(stamp_q)); // R6
    AST_STAMP_FROM_HIT: assert property (@(posedge clk) disable iff (rst)
        $rose(stamp_q) |-> $past(hit)); // R3
    AST_CLEAR_LOSES_TO_EVENT: assert property (@(posedge clk) disable iff (rst)
        (hit && clr_stamp) |=> stamp_q); // R8

endmodule

// File: rtl/evts_regif.sv
`timescale 1ns/1ps
module evts_regif import evts_pkg::*; #(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int SS_W    = 16,
    parameter int EN_BIT  = 25,
    parameter int TSF_BIT = 3,
    parameter int OVF_BIT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              stamp,
    input  logic              ovf,
    input  logic [SS_W-1:0]   cap_ss,
    input  logic [TIME_W-1:0] cap_tm,
    input  logic [DATE_W-1:0] cap_dt,
    output logic              arm,
    output logic              clr_stamp,
    output logic              clr_ovf,
    output logic [DATA_W-1:0] reg_rdata
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata;

    always_comb begin
        if      (reg_addr == ADDR_W'(OFF_CTRL))   sel = SEL_CTRL;
        else if (reg_addr == ADDR_W'(OFF_STAT))   sel = SEL_STAT;
        else if (reg_addr == ADDR_W'(OFF_CLR))    sel = SEL_CLR;
        else if (reg_addr == ADDR_W'(OFF_CAP_SS)) sel = SEL_SS;
        else if (reg_addr == ADDR_W'(OFF_CAP_TM)) sel = SEL_TM;
        else if (reg_addr == ADDR_W'(OFF_CAP_DT)) sel = SEL_DT;
        else                                      sel = SEL_NONE;
    end

    assign clr_stamp = reg_wr && (sel == SEL_CLR) && reg_wdata[TSF_BIT];
    assign clr_ovf   = reg_wr && (sel == SEL_CLR) && reg_wdata[OVF_BIT];

    always_ff @(posedge clk) begin
        if (rst)                            arm <= 1'b0;
        else if (reg_wr && sel == SEL_CTRL) arm <= reg_wdata[EN_BIT];
    end

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_CTRL: rd_mux[EN_BIT] = arm;
            SEL_STAT: begin
                rd_mux[TSF_BIT] = stamp;
                rd_mux[OVF_BIT] = ovf;
            end
            SEL_SS:   rd_mux[SS_W-1:0]   = cap_ss;
            SEL_TM:   rd_mux[TIME_W-1:0] = cap_tm;
            SEL_DT:   rd_mux[DATE_W-1:0] = cap_dt;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata)); // R10
    AST_ARM_ONLY_BY_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> $stable(arm)); // R2

endmodule

// File: rtl/evt_stamp_capture.sv
`timescale 1ns/1ps
module evt_stamp_capture import evts_pkg::*; #(
    parameter int SS_W    = 16,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int EN_BIT  = 25,
    parameter int TSF_BIT = 3,
    parameter int OVF_BIT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SS_W-1:0]   live_subsec,
    input  logic [TIME_W-1:0] live_time,
    input  logic [DATE_W-1:0] live_date,
    input  logic              evt_in,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [SS_W-1:0]   cap_subsec,
    output logic [TIME_W-1:0] cap_time,
    output logic [DATE_W-1:0] cap_date,
    output logic              stamp_flag,
    output logic              ovf_flag
);
    logic armed;
    logic rise;
    logic hit;
    logic clr_stamp;
    logic clr_ovf;
    tod_t cap_tm_s;
    cal_t cap_dt_s;

    evts_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (evt_in),
        .arm  (armed),
        .rise (rise),
        .hit  (hit)
    );

    evts_slot #(.SS_W(SS_W)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .clr_stamp (clr_stamp),
        .clr_ovf   (clr_ovf),
        .live_ss   (live_subsec),
        .live_tm   (tod_t'(live_time)),
        .live_dt   (cal_t'(live_date)),
        .cap_ss    (cap_subsec),
        .cap_tm    (cap_tm_s),
        .cap_dt    (cap_dt_s),
        .stamp_q   (stamp_flag),
        .ovf_q     (ovf_flag)
    );

    assign cap_time = cap_tm_s;
    assign cap_date = cap_dt_s;

    evts_regif #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .SS_W    (SS_W),
        .EN_BIT  (EN_BIT),
        .TSF_BIT (TSF_BIT),
        .OVF_BIT (OVF_BIT)
    ) u_regif (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .stamp     (stamp_flag),
        .ovf       (ovf_flag),
        .cap_ss    (cap_subsec),
        .cap_tm    (cap_time),
        .cap_dt    (cap_date),
        .arm       (armed),
        .clr_stamp (clr_stamp),
        .clr_ovf   (clr_ovf),
        .reg_rdata (reg_rdata)
    );

    AST_ARMED_FOR_STAMP: assert property (@(posedge clk) disable iff (rst)
        $rose(stamp_flag) |-> $past(armed)); // R2
    AST_STAMP_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(stamp_flag) |-> $past(rise)); // R5

endmodule

// File: tb/sim_evt_stamp_capture.sv
`timescale 1ns/1ps
module sim_evt_stamp_capture;

    localparam logic [22:0] TM_KEEP = 23'h7F7F7F;
    localparam logic [23:0] DT_KEEP = 24'h00FF3F;
    localparam logic [31:0] ARM_VAL = 32'h0200_0000;

    typedef struct packed {
        logic [15:0] ss;
        logic [22:0] tm;
        logic [23:0] dt;
        logic [7:0]  clr;
        logic        take;
        logic        exp_tsf;
        logic        exp_ovf;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{16'h0123, 23'h123456, 24'h5A1C27, 8'h00, 1'b1, 1'b1, 1'b0},
        '{16'h0456, 23'h010203, 24'h112233, 8'h00, 1'b0, 1'b1, 1'b1},
        '{16'h7FFF, 23'h7FFFFF, 24'hFFFFFF, 8'h18, 1'b1, 1'b1, 1'b0},
        '{16'h0001, 23'h000000, 24'h012101, 8'h08, 1'b1, 1'b1, 1'b0},
        '{16'hBEEF, 23'h235959, 24'h03F312, 8'h10, 1'b0, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] live_subsec = '0;
    logic [22:0] live_time = '0;
    logic [23:0] live_date = '0;
    logic        evt_in = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] cap_subsec;
    logic [22:0] cap_time;
    logic [23:0] cap_date;
    logic        stamp_flag;
    logic        ovf_flag;

    int checks = 0;
    int errors = 0;
    logic [15:0] e_ss = '0;
    logic [22:0] e_tm = '0;
    logic [23:0] e_dt = '0;

    always #10 clk = ~clk;

    evt_stamp_capture u0 (
        .clk(clk), .rst(rst), .live_subsec(live_subsec), .live_time(live_time),
        .live_date(live_date), .evt_in(evt_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cap_subsec(cap_subsec), .cap_time(cap_time), .cap_date(cap_date),
        .stamp_flag(stamp_flag), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse();
        @(negedge clk);
        evt_in = 1'b1;
        @(negedge clk);
        evt_in = 1'b0;
    endtask

    task automatic pulse_with_clear(input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd2; reg_wdata = d; evt_in = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; evt_in = 1'b0;
    endtask

    task automatic set_live(input logic [15:0] s, input logic [22:0] t, input logic [23:0] d);
        live_subsec = s; live_time = t; live_date = d;
    endtask

    task automatic expect_take();
        e_ss = live_subsec; e_tm = live_time & TM_KEEP; e_dt = live_date & DT_KEEP;
    endtask

    task automatic chk_caps(input string req);
        chk(req, 32'(cap_subsec), 32'(e_ss));
        chk(req, 32'(cap_time), 32'(e_tm));
        chk(req, 32'(cap_date), 32'(e_dt));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 stamp", 32'(stamp_flag), 0);
        chk("R1 ovf", 32'(ovf_flag), 0);
        chk_caps("R1 caps");
        rd(4'd0, d);
        chk("R1 arm", d, 0);

        wr(4'd0, ARM_VAL);
        // R3 R4 R6 R7 vector walk
        for (int i = 0; i < 5; i++) begin
            set_live(VECS[i].ss, VECS[i].tm, VECS[i].dt);
            if (VECS[i].clr != 0) wr(4'd2, 32'(VECS[i].clr));
            pulse();
            if (VECS[i].take) expect_take();
            chk("R3/R6 stamp", 32'(stamp_flag), 32'(VECS[i].exp_tsf));
            chk("R6/R7 ovf", 32'(ovf_flag), 32'(VECS[i].exp_ovf));
            chk_caps("R3 R4 R6 caps");
        end

        // R11 writes to status and capture addresses ignored
        wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd4, 32'hFFFF_FFFF);
        wr(4'd6, 32'h0000_0000);
        chk("R11 stamp", 32'(stamp_flag), 1);
        chk("R11 ovf", 32'(ovf_flag), 1);
        chk_caps("R11 caps");

        // R7 bitwise clear
        wr(4'd2, 32'h0000_0000);
        chk("R7 zero-write stamp", 32'(stamp_flag), 1);
        chk("R7 zero-write ovf", 32'(ovf_flag), 1);
        wr(4'd2, 32'h0000_0010);
        chk("R7 ovf clear", 32'(ovf_flag), 0);
        chk("R7 stamp kept", 32'(stamp_flag), 1);
        wr(4'd2, 32'h0000_0008);
        chk("R7 stamp clear", 32'(stamp_flag), 0);

        // R10 register reads
        rd(4'd1, d);
        chk("R10 status idle", d, 0);
        set_live(16'h3C5A, 23'h5A9AC3, 24'hA7E4B9);
        pulse();
        expect_take();
        rd(4'd1, d);
        chk("R10 status pending", d, 32'h0000_0008);
        rd(4'd4, d);
        chk("R10 read subsec", d, 32'(e_ss));
        rd(4'd5, d);
        chk("R10 read time", d, 32'(e_tm));
        rd(4'd6, d);
        chk("R10 R4 read date", d, 32'(e_dt));
        rd(4'd3, d);
        chk("R10 unmapped", d, 0);
        rd(4'd2, d);
        chk("R10 clear reads zero", d, 0);
        rd(4'd0, d);
        chk("R10 R2 ctrl readback", d, ARM_VAL);
        @(negedge clk);
        chk("R10 rdata holds", reg_rdata, ARM_VAL);

        // R8 event wins over pending clear
        set_live(16'h1111, 23'h112233, 24'h445566);
        pulse_with_clear(32'h0000_0008);
        expect_take();
        chk("R8 stamp", 32'(stamp_flag), 1);
        chk("R8 ovf", 32'(ovf_flag), 0);
        chk_caps("R8 caps");

        // R9 overflow set wins over overflow clear
        set_live(16'h2222, 23'h010101, 24'h020202);
        pulse_with_clear(32'h0000_0010);
        chk("R9 ovf", 32'(ovf_flag), 1);
        chk_caps("R9 caps");

        // R5 long level gives one capture
        wr(4'd2, 32'h0000_0018);
        set_live(16'h0F0F, 23'h204050, 24'h301231);
        @(negedge clk);
        evt_in = 1'b1;
        @(negedge clk);
        expect_take();
        set_live(16'hAAAA, 23'h000001, 24'h000001);
        repeat (5) @(negedge clk);
        evt_in = 1'b0;
        @(negedge clk);
        chk("R5 stamp", 32'(stamp_flag), 1);
        chk("R5 ovf", 32'(ovf_flag), 0);
        chk_caps("R5 caps");

        // R2 disarmed events ignored
        wr(4'd2, 32'h0000_0018);
        wr(4'd0, 32'h0000_0000);
        set_live(16'h5555, 23'h111111, 24'h222222);
        pulse();
        chk("R2 stamp", 32'(stamp_flag), 0);
        chk("R2 ovf", 32'(ovf_flag), 0);
        chk_caps("R2 caps");
        rd(4'd0, d);
        chk("R2 arm cleared", d, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule